// File: doc/BRIEF.md
# Parallel Execute-Packet Splitter

This block sits between an instruction fetch stage and the issue logic of a wide, statically scheduled core. It takes in a fetch packet of eight 32-bit instruction words. It splits that packet into execute packets, which are runs of neighbouring slots that are meant to run in the same cycle. It offers one execute packet per cycle to the issue side. Each instruction word carries its own chaining bit. A set chaining bit joins the following slot to the current group, and a clear bit ends the group. A group never reaches past the last slot of the fetch packet.

Both data edges use a valid/ready handshake. A fetch packet transfers on a rising clock edge where `in_valid` and `in_ready` are both high. `in_ready` stays low while any group of the held packet is still waiting to be issued, so the fetch stage stalls. An execute packet transfers on an edge where `out_valid` and `out_ready` are both high. While `out_ready` is low, the offered group and its descriptors stay unchanged and the block does not advance. With every offered group the block reports a slot mask, the index of the group's first slot and a resource-clash flag. The flag is raised when two slots in the group name the same functional-unit class.

Top module: `xpk_splitter`

## Requirements
- R1: Slot k of `in_packet` occupies bits [32k+31:32k]. Bit 0 of each word is its chaining bit. Bits [3:1] hold a 3-bit functional-unit class. `out_packet` presents the held packet unchanged while a group is offered.
- R2: `in_ready` is high whenever no packet is held. It goes low from the edge that accepts a packet until the edge where the last group of that packet is handshaken.
- R3: A group starts at the first slot that has not yet been issued. It takes in each following slot while the previous slot's chaining bit is 1. `out_mask` has bit k set for every slot k in the group, and `out_start` gives the index of its first slot.
- R4: Chaining bits 0,1,1,0 on slots 0..3 give a first group {0} and then a second group {1,2,3} on the next issue.
- R5: A set chaining bit on slot 7 does not carry over. The group ends at slot 7, and a packet with all chaining bits set issues as one group with mask 8'hFF.
- R6: A packet whose chaining bits are all 0 issues eight single-slot groups. These come on eight consecutive cycles when `out_ready` stays high.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_mask` and `out_start` hold their values, and no group is consumed.
- R8: `out_conflict` is high exactly when `out_valid` is high and two slots set in `out_mask` carry equal unit classes. It is low when no group is offered.
- R9: A synchronous reset discards any partly issued packet. After reset, `in_ready` is high, `out_valid` is low and `out_conflict` is low.
- R10: The first group of an accepted packet is offered in the cycle right after the accepting edge, with `out_start` equal to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Fetch packet offered |
| in_ready | output | 1 | Splitter can take a fetch packet |
| in_packet | input | 256 | Eight instruction words, slot 0 in the low bits |
| out_valid | output | 1 | Execute packet offered |
| out_ready | input | 1 | Issue side takes the offered group |
| out_packet | output | 256 | Held fetch packet |
| out_mask | output | 8 | Slots belonging to the offered group |
| out_start | output | 3 | Index of the group's first slot |
| out_conflict | output | 1 | Two slots of the group share a unit class |

## Verification
Group descriptors and the clash flag are combinational from registered state. They are due in the cycle after the accepting edge, and after that one cycle after each issuing edge. `in_ready` rises in the cycle after the edge that issues the last group. The bench drives inputs and samples outputs on the falling edge, so each check reads the values the next rising edge will act on. The bench sweeps all 256 chaining patterns, and for each pattern it computes the group split and the expected clash flag itself. It inserts back-pressure stalls, and it applies a reset in the middle of a packet.

// File: rtl/xpk_pkg.sv
package xpk_pkg;
  localparam int XPK_SLOTS  = 8;
  localparam int XPK_WORD_W = 32;
  localparam int XPK_UNIT_W = 3;
  localparam int XPK_CHAIN_POS = 0;
  localparam int XPK_UNIT_LSB  = 1;
endpackage

// File: rtl/xpk_group_find.sv
module xpk_group_find #(
  parameter int SLOTS = 8,
  localparam int IDX_W = $clog2(SLOTS)
) (
  input  logic [SLOTS-1:0] chain,
  input  logic [IDX_W-1:0] start,
  output logic [SLOTS-1:0] mask,
  output logic [IDX_W-1:0] last_idx,
  output logic             ends_packet
);
  logic open;

  always_comb begin
    mask     = '0;
    last_idx = start;
    open     = 1'b1;
    for (int i = 0; i < SLOTS; i++) begin
      if (open && (i >= int'(start))) begin
        mask[i]  = 1'b1;
        last_idx = IDX_W'(i);
        if (!chain[i]) open = 1'b0;
      end
    end
    ends_packet = (int'(last_idx) == SLOTS - 1);
  end
endmodule

// File: rtl/xpk_unit_check.sv
module xpk_unit_check #(
  parameter int SLOTS  = 8,
  parameter int UNIT_W = 3
) (
  input  logic [SLOTS-1:0]        mask,
  input  logic [SLOTS*UNIT_W-1:0] units,
  output logic                    clash
);
  logic [SLOTS*SLOTS-1:0] hits;

  for (genvar i = 0; i < SLOTS; i++) begin : g_row
    for (genvar j = 0; j < SLOTS; j++) begin : g_col
      if (j > i) begin : g_pair
        assign hits[i*SLOTS+j] = mask[i] & mask[j] &
          (units[i*UNIT_W +: UNIT_W] == units[j*UNIT_W +: UNIT_W]);
      end else begin : g_none
        assign hits[i*SLOTS+j] = 1'b0;
      end
    end
  end

  assign clash = |hits;
endmodule

// File: rtl/xpk_splitter.sv
module xpk_splitter
  import xpk_pkg::*;
#(
  parameter int SLOTS  = XPK_SLOTS,
  parameter int WORD_W = XPK_WORD_W,
  parameter int UNIT_W = XPK_UNIT_W,
  localparam int IDX_W = $clog2(SLOTS),
  localparam int PKT_W = SLOTS * WORD_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PKT_W-1:0] in_packet,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [PKT_W-1:0] out_packet,
  output logic [SLOTS-1:0] out_mask,
  output logic [IDX_W-1:0] out_start,
  output logic             out_conflict
);
  logic                    busy;
  logic [IDX_W-1:0]        cursor;
  logic [PKT_W-1:0]        pkt;
  logic [SLOTS-1:0]        chain;
  logic [SLOTS*UNIT_W-1:0] units;
  logic [SLOTS-1:0]        grp_mask;
  logic [IDX_W-1:0]        grp_last;
  logic                    grp_ends;
  logic                    grp_clash;
  logic                    take_in;
  logic                    fire;

  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    assign chain[k] = pkt[k*WORD_W + XPK_CHAIN_POS];
    assign units[k*UNIT_W +: UNIT_W] = pkt[k*WORD_W + XPK_UNIT_LSB +: UNIT_W];
  end

  xpk_group_find #(.SLOTS(SLOTS)) u_find (
    .chain       (chain),
    .start       (cursor),
    .mask        (grp_mask),
    .last_idx    (grp_last),
    .ends_packet (grp_ends)
  );

  xpk_unit_check #(.SLOTS(SLOTS), .UNIT_W(UNIT_W)) u_units (
    .mask  (grp_mask),
    .units (units),
    .clash (grp_clash)
  );

  assign in_ready     = !busy;
  assign take_in      = in_valid && !busy;
  assign fire         = busy && out_ready;
  assign out_valid    = busy;
  assign out_packet   = pkt;
  assign out_mask     = busy ? grp_mask : '0;
  assign out_start    = cursor;
  assign out_conflict = busy && grp_clash;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      cursor <= '0;
    end else if (take_in) begin
      busy   <= 1'b1;
      cursor <= '0;
    end else if (fire) begin
      if (grp_ends) begin
        busy   <= 1'b0;
        cursor <= '0;
      end else begin
        cursor <= grp_last + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (take_in) pkt <= in_packet;
  end

  a_r10_first_group: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> (out_valid && out_start == '0));

  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_start) && $stable(out_mask)));

  a_r3_start_in_group: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_mask[out_start]);

  a_r3_advance: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && !out_mask[SLOTS-1]) |=>
      (out_valid && out_start > $past(out_start)));

  a_r5_release: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && out_mask[SLOTS-1]) |=> in_ready);

  a_r8_conflict_valid: assert property (@(posedge clk) disable iff (rst)
    out_conflict |-> (out_valid && $countones(out_mask) > 1));

  a_r2_stall: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !(out_ready && out_mask[SLOTS-1])) |=> !in_ready);
endmodule

// File: tb/sim_xpk_splitter.sv
`timescale 1ns/1ps
module sim_xpk_splitter;
  localparam int S = 8;
  localparam int W = 32;

  logic           clk = 1'b0;
  logic           rst;
  logic           in_valid;
  logic           in_ready;
  logic [S*W-1:0] in_packet;
  logic           out_valid;
  logic           out_ready;
  logic [S*W-1:0] out_packet;
  logic [S-1:0]   out_mask;
  logic [2:0]     out_start;
  logic           out_conflict;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  xpk_splitter u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_packet(in_packet), .out_valid(out_valid), .out_ready(out_ready),
    .out_packet(out_packet), .out_mask(out_mask), .out_start(out_start),
    .out_conflict(out_conflict)
  );

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int unit_of(int p, int k);
    if (p % 3 == 0) return k;
    return ((k * 3 + p) / 2) % 8;
  endfunction

  function automatic logic [W-1:0] mkword(int p, int k);
    logic [27:0] fill;
    logic [2:0]  u;
    fill = 28'(p * 131 + k * 7);
    u    = 3'(unit_of(p, k));
    return {fill, u, 1'(p >> k)};
  endfunction

  task automatic run_packet(int p, bit stall);
    logic [S*W-1:0] pkt;
    int s, e, grp;
    logic [S-1:0] em;
    bit ec;
    string tag;
    for (int k = 0; k < S; k++) pkt[k*W +: W] = mkword(p, k);
    @(negedge clk);
    in_packet = pkt;
    in_valid  = 1'b1;
    chk("R2", "in_ready idle", in_ready, 1);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R2", "in_ready held", in_ready, 0);
    chk("R1", "out_packet", (out_packet == pkt), 1);
    s = 0;
    grp = 0;
    while (s < S) begin
      e = s;
      while (e < S - 1 && ((p >> e) & 1) == 1) e++;
      em = '0;
      for (int k = s; k <= e; k++) em[k] = 1'b1;
      ec = 0;
      for (int a = s; a <= e; a++)
        for (int b = a + 1; b <= e; b++)
          if (unit_of(p, a) == unit_of(p, b)) ec = 1;
      if (stall && grp == 1) begin
        out_ready = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R7", "valid in stall", out_valid, 1);
        chk("R7", "start in stall", out_start, s);
        chk("R7", "mask in stall", out_mask, em);
        out_ready = 1'b1;
      end
      if (p == 8'h06 && s < 4) tag = "R4";
      else if (p == 0) tag = "R6";
      else if (e == S - 1 && ((p >> (S - 1)) & 1) == 1) tag = "R5";
      else tag = "R3";
      if (grp == 0) chk("R10", "first start", out_start, 0);
      chk(tag, "out_valid", out_valid, 1);
      chk(tag, "out_mask", out_mask, em);
      chk(tag, "out_start", out_start, s);
      chk("R8", "out_conflict", out_conflict, ec);
      if (s < S - 1 || grp == 0) chk("R2", "stall mid packet", in_ready, 0);
      @(posedge clk);
      @(negedge clk);
      grp++;
      s = e + 1;
    end
    if (p == 0) chk("R6", "group count", grp, 8);
    if (p == 8'hFF) chk("R5", "group count", grp, 1);
    chk("R2", "in_ready after last", in_ready, 1);
    chk("R8", "conflict idle", out_conflict, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; in_packet = '0; out_ready = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R9", "reset in_ready", in_ready, 1);
    chk("R9", "reset out_valid", out_valid, 0);
    chk("R9", "reset conflict", out_conflict, 0);

    for (int p = 0; p < 256; p++) run_packet(p, (p % 16) == 5);

    // R9: reset in the middle of an all-separate packet
    @(negedge clk);
    for (int k = 0; k < S; k++) in_packet[k*W +: W] = mkword(0, k);
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R9", "mid packet busy", out_valid, 1);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R9", "mid reset in_ready", in_ready, 1);
    chk("R9", "mid reset out_valid", out_valid, 0);
    run_packet(8'h06, 1'b0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule